// File: doc/BRIEF.md
# Hardware Cursor Overlay

The block lays a 32 by 32 pixel cursor over a stream of 24-bit pixels on its way from the display pipeline to the output. Software loads the cursor shape and position through a 32-bit register bus. The shape is held as two bit planes of 32 rows each. The shape plane marks which pixels of the cursor are opaque. The colour plane picks, for each opaque pixel, one of two overlay colours that the palette supplies as inputs.

Each incoming pixel carries its own column and row coordinates. When a pixel lies inside the cursor window and its shape bit is set, it is replaced by the chosen overlay colour. Every other pixel passes through unchanged. The result leaves one clock later through a registered output. Its valid flag and coordinates are delayed by the same clock, so they stay aligned with the colour.

The screen size is set by parameters. Cursor pixels that fall outside the screen are clipped. After reset the cursor sits at an off-screen position, so nothing is drawn until software places it.

Top module: `cursor_overlay`

## Requirements
- R1: After reset both cursor coordinates are 0xF000. While they keep that value, every pixel inside the screen passes through unchanged.
- R2: A bus write to byte offset 0x8FC sets the cursor column from write data bits [31:16] and the cursor row from bits [15:0].
- R3: Bus writes to offsets 0x900 through 0x97F load the 32 shape rows. The row written is (offset - 0x900) / 4.
- R4: Bus writes to offsets 0x980 through 0x9FF load the 32 colour-select rows. The row written is (offset - 0x980) / 4.
- R5: A pixel at row y can be covered only when cursorY <= y < cursorY + 32. This sum is formed without wrapping, so a cursor near row 0xFFFF does not reach rows near 0.
- R6: Within a cursor row, bit 31 of the stored word maps to column cursorX. Each lower bit maps one column further right, so bit (31 - (x - cursorX)) applies at column x.
- R7: A covered pixel whose shape bit is 1 becomes overlay colour 3 when its select bit is 1, and overlay colour 2 when its select bit is 0. A covered pixel whose shape bit is 0 passes unchanged.
- R8: Pixels at a column >= WIDTH or a row >= HEIGHT are never replaced. No cursor is drawn at all while cursorX >= WIDTH.
- R9: A bus read of offset 0x818 returns the last value written there, with bit 25 forced to 1. A read of any other offset returns 0. Read data appears on the clock after the read strobe.
- R10: The pixel output is valid exactly one clock after a valid input pixel, and carries that pixel's column and row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after the strobe |
| ovl_col2 | input | 24 | Overlay colour used when the select bit is 0 |
| ovl_col3 | input | 24 | Overlay colour used when the select bit is 1 |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_rgb | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel row |
| out_rgb | output | 24 | Output pixel colour |

## Verification
A corrupted shape or select row appears on the very next pixel that lands in that cursor row. It shows as the wrong overlay colour, or as a pass-through where a colour was due, and the probe pixels are placed on the row and column edges to catch it. A wrong cursor position, such as swapped coordinate halves or a wrapped window end, moves the whole pattern, so pixels just inside and just outside each window edge are checked one clock after they enter. A bad misc register or a bad read decode shows on the read data one clock after the strobe.

// File: rtl/cur_pkg.sv
package cur_pkg;
  localparam int ADDR_W    = 12;
  localparam int ROWS      = 32;
  localparam int ROW_AW    = $clog2(ROWS);
  localparam int PLANES    = 2;
  localparam int PL_SHAPE  = 0;
  localparam int PL_SELECT = 1;
  localparam logic [ADDR_W-1:0] OFS_POS    = 12'h8FC;
  localparam logic [ADDR_W-1:0] OFS_MISC   = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_SHAPE  = 12'h900;
  localparam logic [ADDR_W-1:0] OFS_SELECT = 12'h980;
  localparam int STATUS_BIT = 25;
  localparam logic [15:0] OFFSCREEN = 16'hF000;
endpackage

// File: rtl/cur_regs.sv
module cur_regs
  import cur_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [CW-1:0]     pos_x,
  output logic [CW-1:0]     pos_y,
  output logic [PLANES-1:0] plane_we,
  output logic [ROW_AW-1:0] plane_wa
);
  localparam int WIN_LSB = ROW_AW + 2;

  logic [31:0] misc_q;
  logic        hit_shape, hit_select;

  // each plane is a 128-byte window; the row index sits above the byte lane
  assign hit_shape  = addr[ADDR_W-1:WIN_LSB] == OFS_SHAPE[ADDR_W-1:WIN_LSB];
  assign hit_select = addr[ADDR_W-1:WIN_LSB] == OFS_SELECT[ADDR_W-1:WIN_LSB];
  assign plane_wa   = addr[WIN_LSB-1:2];

  always_comb begin
    plane_we            = '0;
    plane_we[PL_SHAPE]  = wr && hit_shape;
    plane_we[PL_SELECT] = wr && hit_select;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_x  <= CW'(OFFSCREEN);
      pos_y  <= CW'(OFFSCREEN);
      misc_q <= '0;
    end else if (wr) begin
      if (addr == OFS_POS) begin
        pos_x <= wdata[31:16];
        pos_y <= wdata[15:0];
      end
      if (addr == OFS_MISC) misc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd && addr == OFS_MISC) rdata <= misc_q | (32'd1 << STATUS_BIT);
    else rdata <= '0;
  end
endmodule

// File: rtl/cur_plane.sv
module cur_plane
  import cur_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_AW-1:0] wa,
  input  logic [31:0]       wd,
  input  logic [ROW_AW-1:0] ra,
  output logic [31:0]       rd
);
  // small distributed RAM: synchronous write, asynchronous read
  logic [31:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/cur_mix.sv
module cur_mix
  import cur_pkg::*;
#(
  parameter int WIDTH  = 1024,
  parameter int HEIGHT = 768,
  parameter int CW     = 16,
  parameter int PW     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic [CW-1:0]     pix_x,
  input  logic [CW-1:0]     pix_y,
  input  logic [PW-1:0]     pix_rgb,
  input  logic [PW-1:0]     col2,
  input  logic [PW-1:0]     col3,
  input  logic [CW-1:0]     pos_x,
  input  logic [CW-1:0]     pos_y,
  output logic [ROW_AW-1:0] row_sel,
  input  logic [31:0]       shape_row,
  input  logic [31:0]       select_row,
  output logic              out_valid,
  output logic [CW-1:0]     out_x,
  output logic [CW-1:0]     out_y,
  output logic [PW-1:0]     out_rgb
);
  logic [CW-1:0]     dx, dy;
  logic              in_rows, in_cols, on_screen, draw;
  logic [ROW_AW-1:0] bit_idx;
  logic [PW-1:0]     next_rgb;

  // offsets are taken only when the pixel is at or past the corner, so no wrap
  assign dx = pix_x - pos_x;
  assign dy = pix_y - pos_y;
  assign in_rows   = (pix_y >= pos_y) && (dy < CW'(ROWS));
  assign in_cols   = (pix_x >= pos_x) && (dx < CW'(ROWS));
  assign on_screen = (pix_x < CW'(WIDTH)) && (pix_y < CW'(HEIGHT)) &&
                     (pos_x < CW'(WIDTH));
  assign row_sel   = dy[ROW_AW-1:0];
  assign bit_idx   = ~dx[ROW_AW-1:0];
  assign draw      = in_rows && in_cols && on_screen && shape_row[bit_idx];

  always_comb begin
    next_rgb = pix_rgb;
    if (draw) next_rgb = select_row[bit_idx] ? col3 : col2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      out_x     <= pix_x;
      out_y     <= pix_y;
      out_rgb   <= next_rgb;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cur_pkg::*;
#(
  parameter int WIDTH  = 1024,
  parameter int HEIGHT = 768,
  parameter int CW     = 16,
  parameter int PW     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PW-1:0]     ovl_col2,
  input  logic [PW-1:0]     ovl_col3,
  input  logic              pix_valid,
  input  logic [CW-1:0]     pix_x,
  input  logic [CW-1:0]     pix_y,
  input  logic [PW-1:0]     pix_rgb,
  output logic              out_valid,
  output logic [CW-1:0]     out_x,
  output logic [CW-1:0]     out_y,
  output logic [PW-1:0]     out_rgb
);
  logic [CW-1:0]     cur_x, cur_y;
  logic [PLANES-1:0] plane_we;
  logic [ROW_AW-1:0] plane_wa, row_sel;
  logic [31:0]       plane_row [PLANES];

  cur_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pos_x(cur_x), .pos_y(cur_y),
    .plane_we(plane_we), .plane_wa(plane_wa)
  );

  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    cur_plane u_plane (
      .clk(clk), .we(plane_we[g]), .wa(plane_wa), .wd(reg_wdata),
      .ra(row_sel), .rd(plane_row[g])
    );
  end

  cur_mix #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .CW(CW), .PW(PW)) u_mix (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pix_rgb(pix_rgb), .col2(ovl_col2), .col3(ovl_col3),
    .pos_x(cur_x), .pos_y(cur_y), .row_sel(row_sel),
    .shape_row(plane_row[PL_SHAPE]), .select_row(plane_row[PL_SELECT]),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cur_pkg::*;
#(
  parameter int WIDTH  = 1024,
  parameter int HEIGHT = 768,
  parameter int CW     = 16,
  parameter int PW     = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              pix_valid,
  input logic [CW-1:0]     pix_x,
  input logic [CW-1:0]     pix_y,
  input logic [PW-1:0]     pix_rgb,
  input logic              out_valid,
  input logic [CW-1:0]     out_x,
  input logic [CW-1:0]     out_y,
  input logic [PW-1:0]     out_rgb,
  input logic [CW-1:0]     pos_x,
  input logic [CW-1:0]     pos_y
);
  assert_valid_on_R10: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);
  assert_valid_off_R10: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);
  assert_coords_R10: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> (out_x == $past(pix_x)) && (out_y == $past(pix_y)));
  assert_above_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (pix_y < pos_y) |=> out_rgb == $past(pix_rgb));
  assert_left_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (pix_x < pos_x) |=> out_rgb == $past(pix_rgb));
  assert_clip_R8: assert property (@(posedge clk) disable iff (rst)
    (pix_x >= CW'(WIDTH) || pix_y >= CW'(HEIGHT)) |=> out_rgb == $past(pix_rgb));
  assert_misc_status_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_MISC) |=> reg_rdata[STATUS_BIT]);
  assert_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_addr == OFS_MISC) |=> reg_rdata == 32'd0);
endmodule

bind cursor_overlay cursor_overlay_chk #(
  .WIDTH(WIDTH), .HEIGHT(HEIGHT), .CW(CW), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
  .pix_rgb(pix_rgb), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
  .out_rgb(out_rgb), .pos_x(cur_x), .pos_y(cur_y)
);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;
  localparam logic [23:0] C2 = 24'hAA0000;
  localparam logic [23:0] C3 = 24'h00BB00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0, out_x, out_y;
  logic [23:0] pix_rgb = '0, out_rgb;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovl_col2(C2), .ovl_col3(C3), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pix_rgb(pix_rgb), .out_valid(out_valid), .out_x(out_x),
    .out_y(out_y), .out_rgb(out_rgb)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read_chk(input logic [11:0] a, input logic [31:0] exp,
                              input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    check(reg_rdata, exp, tag);
    reg_rd = 1'b0;
  endtask

  function automatic logic [23:0] base_rgb(input logic [15:0] x, input logic [15:0] y);
    return {x[7:0], y[7:0], 8'h5A};
  endfunction

  // pixel enters at one edge and is checked right after the next edge
  task automatic pix_chk(input logic [15:0] x, input logic [15:0] y,
                         input logic [23:0] exp, input string tag);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = x; pix_y = y; pix_rgb = base_rgb(x, y);
    @(negedge clk);
    check({8'h0, out_rgb}, {8'h0, exp}, tag);
    pix_valid = 1'b0;
  endtask

  function automatic logic [11:0] shape_ofs(input int r);
    return 12'h900 + 12'(r * 4);
  endfunction
  function automatic logic [11:0] sel_ofs(input int r);
    return 12'h980 + 12'(r * 4);
  endfunction

  task automatic t_reset;
    reg_read_chk(12'h818, 32'h0200_0000, "R1/R9 misc after reset");
    check({31'd0, out_valid}, 32'd0, "R10 out_valid idle after reset");
    pix_chk(16'd0, 16'd0, base_rgb(16'd0, 16'd0), "R1 pixel (0,0) passes");
    pix_chk(16'd1023, 16'd767, base_rgb(16'd1023, 16'd767), "R1 corner passes");
  endtask

  task automatic t_clear;
    for (int r = 0; r < 32; r++) begin
      reg_write(shape_ofs(r), 32'h0);
      reg_write(sel_ofs(r), 32'h0);
    end
  endtask

  task automatic t_readback;
    reg_write(12'h818, 32'h0000_00A5);
    reg_read_chk(12'h818, 32'h0200_00A5, "R9 misc bit25 forced");
    reg_write(12'h818, 32'h8200_0001);
    reg_read_chk(12'h818, 32'h8200_0001, "R9 misc stored value");
    reg_write(12'h8FC, 32'h1234_5678);
    reg_read_chk(12'h8FC, 32'h0, "R9 position reads zero");
    reg_write(shape_ofs(3), 32'hFFFF_FFFF);
    reg_read_chk(shape_ofs(3), 32'h0, "R9 shape row reads zero");
    reg_write(shape_ofs(3), 32'h0);
  endtask

  task automatic t_colours;
    reg_write(12'h8FC, 32'h0064_0032);       // column 100, row 50
    reg_write(shape_ofs(0), 32'h8000_0001);
    reg_write(sel_ofs(0), 32'h8000_0000);
    pix_chk(16'd100, 16'd50, C3, "R2/R6/R7 first column colour 3");
    pix_chk(16'd131, 16'd50, C2, "R6/R7 last column colour 2");
    pix_chk(16'd101, 16'd50, base_rgb(16'd101, 16'd50), "R7 shape 0 passes");
    pix_chk(16'd99, 16'd50, base_rgb(16'd99, 16'd50), "R6 left of cursor");
    pix_chk(16'd132, 16'd50, base_rgb(16'd132, 16'd50), "R6 right of cursor");
    reg_write(shape_ofs(5), 32'h4000_0000);
    reg_write(sel_ofs(5), 32'h4000_0000);
    pix_chk(16'd101, 16'd55, C3, "R3/R4 row 5 column 1");
    pix_chk(16'd101, 16'd54, base_rgb(16'd101, 16'd54), "R3 row 4 empty");
    reg_write(sel_ofs(5), 32'h0);
    pix_chk(16'd101, 16'd55, C2, "R4 select cleared gives colour 2");
  endtask

  task automatic t_vertical;
    reg_write(shape_ofs(31), 32'hFFFF_FFFF);
    reg_write(sel_ofs(31), 32'hFFFF_FFFF);
    pix_chk(16'd100, 16'd81, C3, "R5 last row covered");
    pix_chk(16'd100, 16'd82, base_rgb(16'd100, 16'd82), "R5 row below window");
    pix_chk(16'd100, 16'd49, base_rgb(16'd100, 16'd49), "R5 row above window");
    reg_write(shape_ofs(16), 32'hFFFF_FFFF);
    reg_write(12'h8FC, 32'h0000_FFF0);       // column 0, row 0xFFF0
    pix_chk(16'd0, 16'd0, base_rgb(16'd0, 16'd0), "R5 no wrap at top");
    reg_write(shape_ofs(16), 32'h0);
  endtask

  task automatic t_clip;
    reg_write(shape_ofs(0), 32'hFFFF_FFFF);
    reg_write(sel_ofs(0), 32'h0);
    reg_write(12'h8FC, 32'h03F2_000A);       // column 1010, row 10
    pix_chk(16'd1023, 16'd10, C2, "R8 last screen column drawn");
    pix_chk(16'd1024, 16'd10, base_rgb(16'd1024, 16'd10), "R8 column at width");
    reg_write(12'h8FC, 32'h0400_000A);       // column 1024
    pix_chk(16'd1025, 16'd10, base_rgb(16'd1025, 16'd10), "R8 cursorX at width");
    reg_write(12'h8FC, 32'h0064_02FF);       // column 100, row 767
    reg_write(shape_ofs(1), 32'hFFFF_FFFF);
    pix_chk(16'd100, 16'd767, C2, "R8 last screen row drawn");
    pix_chk(16'd100, 16'd768, base_rgb(16'd100, 16'd768), "R8 row at height");
  endtask

  task automatic t_latency;
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'd321; pix_y = 16'd123; pix_rgb = 24'h0F0F0F;
    @(negedge clk);
    check({31'd0, out_valid}, 32'd1, "R10 valid after one clock");
    check({16'd0, out_x}, 32'd321, "R10 column carried");
    check({16'd0, out_y}, 32'd123, "R10 row carried");
    pix_valid = 1'b0;
    @(negedge clk);
    check({31'd0, out_valid}, 32'd0, "R10 valid drops");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clear();
    t_readback();
    t_colours();
    t_vertical();
    t_clip();
    t_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule